// File: doc/BRIEF.md
# Segmented Pre/Post-Trigger Waveform Capture

This block turns a continuous stream of 8-bit converter samples into a series of triggered waveform records. After it is armed, samples flow into a small circular area of the current record slot and keep overwriting it. Once that ring has been filled with the programmed number of samples, a trigger pulse is accepted. The block then waits a programmed number of clock cycles and writes the programmed number of following samples into a linear area of the same slot. Each completed record gets a slot of its own, so earlier records stay readable while later ones are taken. A slice ends when the programmed number of records is done. Capture then halts until the next arm.

Readout is a valid/ready stream. A request names how many records are wanted, and the block returns the smaller of that number and the number actually completed, starting from the first record of the slice. Within each record the ring is rotated on the fly so that samples leave oldest first. The post-trigger samples follow, and a last flag marks the final sample of every record. No separate pass is needed to put the ring into time order.

Top module: `wseg_capture`

## Requirements
- R1: After reset, rec_count is 0, slice_done is 0 and out_valid is 0. No samples or triggers are captured before the first arm pulse.
- R2: An arm pulse latches cfg_pre_len, cfg_post_len, cfg_delay and cfg_waves, clears rec_count and slice_done, and restarts the ring. The sample in the arm cycle is not stored.
- R3: A trigger is accepted only if cfg_pre_len valid samples were stored in earlier cycles since the arm or since the previous record finished. Otherwise it is ignored.
- R4: The pre-trigger part of a record is the last cfg_pre_len valid samples up to and including the trigger cycle, in time order, oldest first.
- R5: After a trigger accepted in cycle T, the cycles T+1 to T+cfg_delay are discarded. The post-trigger part is the first cfg_post_len valid samples from cycle T+cfg_delay+1 onward.
- R6: Triggers during the delay or the post-trigger phase are ignored.
- R7: Samples with adc_vld low are never stored and do not advance any count.
- R8: rec_count rises by one when a record's last post-trigger sample is stored. When it reaches cfg_waves, slice_done goes to 1 and further triggers are ignored until the next arm.
- R9: A rd_req pulse streams min(rd_nrec, rec_count) records, record 0 first. Each record has cfg_pre_len+cfg_post_len beats, out_rec carries the record index, and out_last is 1 exactly on the final beat. A count of zero produces no beats.
- R10: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_rec hold their values.
- R11: Completed records remain unchanged and readable after later records of the same slice have been captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start a new slice with the current configuration |
| cfg_pre_len | input | LEN_PW | Pre-trigger samples per record, 1..PRE_MAX |
| cfg_post_len | input | LEN_QW | Post-trigger samples per record, 1..POST_MAX |
| cfg_delay | input | DLY_W | Cycles skipped between trigger and post capture |
| cfg_waves | input | CNT_W | Records per slice, 1..NREC |
| adc_data | input | DATA_W | Sample value |
| adc_vld | input | 1 | Sample qualifier |
| trig | input | 1 | Trigger event |
| rd_req | input | 1 | Readout request pulse |
| rd_nrec | input | CNT_W | Records wanted by the request |
| out_ready | input | 1 | Downstream accepts a beat |
| out_valid | output | 1 | Beat present |
| out_data | output | DATA_W | Sample of the beat |
| out_last | output | 1 | Final beat of a record |
| out_rec | output | SLOT_W | Record index of the beat |
| rec_count | output | CNT_W | Completed records in this slice |
| slice_done | output | 1 | Programmed record count reached |

## Verification
The bound checker watches several rules on every cycle. An accepted trigger always finds the ring full, and an accept is never followed at once by another. No trigger is accepted once the slice is done. The record count moves only on a completion or an arm, an arm clears the count, out_last never appears without out_valid, and a stalled beat holds still. Whether the samples come out in the right order can only be shown by the bench. The same holds for the correct rotation, the correct handling of the trigger delay and gaps, and readout of earlier records after later captures. The bench rebuilds each expected record from its own log of driven samples over a sweep of ring length, post length, delay, ring rotation and gap patterns.

// File: rtl/wseg_pkg.sv
package wseg_pkg;

  typedef enum logic [2:0] {
    CAP_IDLE,
    CAP_FILL,
    CAP_ARMED,
    CAP_DELAY,
    CAP_POST,
    CAP_DONE
  } cap_state_t;

  // Next ring write position for a ring of 'len' entries.
  function automatic int unsigned ring_step(int unsigned wp, int unsigned len);
    return (wp + 1 >= len) ? 0 : wp + 1;
  endfunction

  // Slot offset of readout beat k: rotated ring first, then the linear part.
  function automatic int unsigned order_offset(int unsigned k, int unsigned oldest,
                                               int unsigned pre_len, int unsigned pre_max);
    int unsigned p;
    if (k < pre_len) begin
      p = oldest + k;
      if (p >= pre_len) p = p - pre_len;
      return p;
    end
    return pre_max + (k - pre_len);
  endfunction

endpackage

// File: rtl/wseg_store.sv
module wseg_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/wseg_ctrl.sv
module wseg_ctrl import wseg_pkg::*; #(
  parameter int PRE_MAX = 16,
  parameter int NREC    = 8,
  parameter int DLY_W   = 8,
  parameter int REC_MAX = 32,
  parameter int PI_W    = 4,
  parameter int QI_W    = 4,
  parameter int LEN_PW  = 5,
  parameter int LEN_QW  = 5,
  parameter int SLOT_W  = 3,
  parameter int CNT_W   = 4,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [LEN_PW-1:0] cfg_pre_len,
  input  logic [LEN_QW-1:0] cfg_post_len,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic [CNT_W-1:0]  cfg_waves,
  input  logic              adc_vld,
  input  logic              trig,
  input  logic [SLOT_W-1:0] ptr_idx,
  output logic [PI_W-1:0]   ptr_out,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LEN_PW-1:0] pre_len_q,
  output logic [LEN_QW-1:0] post_len_q,
  output logic [CNT_W-1:0]  rec_count,
  output logic              slice_done,
  output logic              trig_accept,
  output logic              rec_done,
  output logic              ring_full
);

  cap_state_t        st;
  logic [PI_W-1:0]   wp;
  logic [LEN_PW-1:0] fill;
  logic [QI_W-1:0]   pidx;
  logic [DLY_W-1:0]  dcnt;
  logic [DLY_W-1:0]  delay_q;
  logic [CNT_W-1:0]  waves_q;
  logic [SLOT_W-1:0] slot;
  logic [PI_W-1:0]   ptr_q [NREC];

  logic            pre_wr;
  logic            post_wr;
  logic            last_wave;
  logic [PI_W-1:0] wp_nxt;

  assign wp_nxt      = PI_W'(ring_step(32'(wp), 32'(pre_len_q)));
  assign pre_wr      = ((st == CAP_FILL) || (st == CAP_ARMED)) && adc_vld;
  assign post_wr     = (st == CAP_POST) && adc_vld;
  assign ring_full   = (32'(fill) == 32'(pre_len_q));
  assign trig_accept = (st == CAP_ARMED) && trig;
  assign rec_done    = post_wr && (32'(pidx) + 1 == 32'(post_len_q));
  assign last_wave   = (32'(rec_count) + 1 >= 32'(waves_q));
  assign wr_en       = pre_wr || post_wr;
  assign wr_addr     = ADDR_W'(32'(slot) * REC_MAX +
                               (pre_wr ? 32'(wp) : PRE_MAX + 32'(pidx)));
  assign ptr_out     = ptr_q[ptr_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= CAP_IDLE;
      wp         <= '0;
      fill       <= '0;
      pidx       <= '0;
      dcnt       <= '0;
      delay_q    <= '0;
      waves_q    <= '0;
      pre_len_q  <= LEN_PW'(1);
      post_len_q <= LEN_QW'(1);
      slot       <= '0;
      rec_count  <= '0;
      slice_done <= 1'b0;
      for (int i = 0; i < NREC; i++) ptr_q[i] <= '0;
    end else if (arm) begin
      st         <= CAP_FILL;
      pre_len_q  <= cfg_pre_len;
      post_len_q <= cfg_post_len;
      delay_q    <= cfg_delay;
      waves_q    <= cfg_waves;
      wp         <= '0;
      fill       <= '0;
      slot       <= '0;
      rec_count  <= '0;
      slice_done <= 1'b0;
    end else begin
      unique case (st)
        CAP_FILL: begin
          if (adc_vld) begin
            wp   <= wp_nxt;
            fill <= fill + 1'b1;
            if (32'(fill) + 1 == 32'(pre_len_q)) st <= CAP_ARMED;
          end
        end
        CAP_ARMED: begin
          if (adc_vld) wp <= wp_nxt;
          if (trig) begin
            ptr_q[slot] <= adc_vld ? wp_nxt : wp;
            dcnt        <= delay_q;
            pidx        <= '0;
            st          <= (delay_q == '0) ? CAP_POST : CAP_DELAY;
          end
        end
        CAP_DELAY: begin
          dcnt <= dcnt - 1'b1;
          if (dcnt == DLY_W'(1)) st <= CAP_POST;
        end
        CAP_POST: begin
          if (adc_vld) begin
            if (rec_done) begin
              rec_count <= rec_count + 1'b1;
              if (last_wave) begin
                st         <= CAP_DONE;
                slice_done <= 1'b1;
              end else begin
                st   <= CAP_FILL;
                fill <= '0;
                wp   <= '0;
                slot <= slot + 1'b1;
              end
            end else begin
              pidx <= pidx + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/wseg_reader.sv
module wseg_reader import wseg_pkg::*; #(
  parameter int PRE_MAX = 16,
  parameter int REC_MAX = 32,
  parameter int PI_W    = 4,
  parameter int LEN_PW  = 5,
  parameter int LEN_QW  = 5,
  parameter int SLOT_W  = 3,
  parameter int CNT_W   = 4,
  parameter int ADDR_W  = 8,
  parameter int K_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [CNT_W-1:0]  rd_nrec,
  input  logic [CNT_W-1:0]  rec_count,
  input  logic [LEN_PW-1:0] pre_len_q,
  input  logic [LEN_QW-1:0] post_len_q,
  input  logic [PI_W-1:0]   ptr_in,
  input  logic              out_ready,
  output logic [SLOT_W-1:0] ptr_idx,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              out_valid,
  output logic              out_last,
  output logic [SLOT_W-1:0] out_rec
);

  logic              busy;
  logic [SLOT_W-1:0] rec;
  logic [K_W-1:0]    k;
  logic [CNT_W-1:0]  nrec_q;
  logic [CNT_W-1:0]  grant;
  int unsigned       rec_len;

  assign rec_len   = 32'(pre_len_q) + 32'(post_len_q);
  assign grant     = (rd_nrec < rec_count) ? rd_nrec : rec_count;
  assign ptr_idx   = rec;
  assign out_rec   = rec;
  assign out_valid = busy;
  assign out_last  = busy && (32'(k) + 1 == rec_len);
  assign rd_addr   = ADDR_W'(32'(rec) * REC_MAX +
                             order_offset(32'(k), 32'(ptr_in), 32'(pre_len_q), PRE_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      rec    <= '0;
      k      <= '0;
      nrec_q <= '0;
    end else if (!busy) begin
      if (rd_req && (grant != '0)) begin
        busy   <= 1'b1;
        rec    <= '0;
        k      <= '0;
        nrec_q <= grant;
      end
    end else if (out_ready) begin
      if (out_last) begin
        k <= '0;
        if (32'(rec) + 1 == 32'(nrec_q)) busy <= 1'b0;
        else                             rec  <= rec + 1'b1;
      end else begin
        k <= k + 1'b1;
      end
    end
  end

endmodule

// File: rtl/wseg_capture.sv
module wseg_capture #(
  parameter int DATA_W   = 8,
  parameter int PRE_MAX  = 16,
  parameter int POST_MAX = 16,
  parameter int NREC     = 8,
  parameter int DLY_W    = 8,
  localparam int REC_MAX = PRE_MAX + POST_MAX,
  localparam int PI_W    = $clog2(PRE_MAX > 1 ? PRE_MAX : 2),
  localparam int QI_W    = $clog2(POST_MAX > 1 ? POST_MAX : 2),
  localparam int LEN_PW  = $clog2(PRE_MAX + 1),
  localparam int LEN_QW  = $clog2(POST_MAX + 1),
  localparam int SLOT_W  = $clog2(NREC > 1 ? NREC : 2),
  localparam int CNT_W   = $clog2(NREC + 1),
  localparam int DEPTH   = NREC * REC_MAX,
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int K_W     = $clog2(REC_MAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [LEN_PW-1:0] cfg_pre_len,
  input  logic [LEN_QW-1:0] cfg_post_len,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic [CNT_W-1:0]  cfg_waves,
  input  logic [DATA_W-1:0] adc_data,
  input  logic              adc_vld,
  input  logic              trig,
  input  logic              rd_req,
  input  logic [CNT_W-1:0]  rd_nrec,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic [SLOT_W-1:0] out_rec,
  output logic [CNT_W-1:0]  rec_count,
  output logic              slice_done
);

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic [LEN_PW-1:0] pre_len_q;
  logic [LEN_QW-1:0] post_len_q;
  logic [SLOT_W-1:0] ptr_idx;
  logic [PI_W-1:0]   ptr_out;
  logic              trig_accept;
  logic              rec_done;
  logic              ring_full;

  wseg_ctrl #(
    .PRE_MAX(PRE_MAX), .NREC(NREC), .DLY_W(DLY_W), .REC_MAX(REC_MAX),
    .PI_W(PI_W), .QI_W(QI_W), .LEN_PW(LEN_PW), .LEN_QW(LEN_QW),
    .SLOT_W(SLOT_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm),
    .cfg_pre_len(cfg_pre_len), .cfg_post_len(cfg_post_len),
    .cfg_delay(cfg_delay), .cfg_waves(cfg_waves),
    .adc_vld(adc_vld), .trig(trig),
    .ptr_idx(ptr_idx), .ptr_out(ptr_out),
    .wr_en(wr_en), .wr_addr(wr_addr),
    .pre_len_q(pre_len_q), .post_len_q(post_len_q),
    .rec_count(rec_count), .slice_done(slice_done),
    .trig_accept(trig_accept), .rec_done(rec_done), .ring_full(ring_full)
  );

  wseg_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(adc_data),
    .rd_addr(rd_addr), .rd_data(out_data)
  );

  wseg_reader #(
    .PRE_MAX(PRE_MAX), .REC_MAX(REC_MAX), .PI_W(PI_W), .LEN_PW(LEN_PW),
    .LEN_QW(LEN_QW), .SLOT_W(SLOT_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .K_W(K_W)
  ) u_reader (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_nrec(rd_nrec),
    .rec_count(rec_count), .pre_len_q(pre_len_q), .post_len_q(post_len_q),
    .ptr_in(ptr_out), .out_ready(out_ready), .ptr_idx(ptr_idx),
    .rd_addr(rd_addr), .out_valid(out_valid), .out_last(out_last),
    .out_rec(out_rec)
  );

endmodule

// File: rtl/wseg_capture_chk.sv
module wseg_capture_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4,
  parameter int SLOT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm,
  input logic              trig_accept,
  input logic              ring_full,
  input logic              rec_done,
  input logic [CNT_W-1:0]  rec_count,
  input logic              slice_done,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_last,
  input logic [SLOT_W-1:0] out_rec
);

  // R3
  accept_needs_full_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_accept |-> ring_full);

  // R6
  no_back_to_back_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_accept |=> !trig_accept);

  // R8
  halted_after_slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slice_done |-> !trig_accept);

  // R8
  count_moves_on_completion_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rec_done && !arm) |=> $stable(rec_count));

  // R2
  arm_clears_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (rec_count == '0) && !slice_done);

  // R9
  last_implies_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R10
  stall_holds_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !arm) |=>
      out_valid && $stable(out_data) && $stable(out_rec) && $stable(out_last));

endmodule

bind wseg_capture wseg_capture_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_chk (.*);

// File: tb/sim_wseg_capture.sv
module sim_wseg_capture;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arm = 1'b0;
  logic [4:0] cfg_pre_len = 5'd1;
  logic [4:0] cfg_post_len = 5'd1;
  logic [7:0] cfg_delay = 8'd0;
  logic [3:0] cfg_waves = 4'd1;
  logic [7:0] adc_data = 8'd0;
  logic       adc_vld = 1'b0;
  logic       trig = 1'b0;
  logic       rd_req = 1'b0;
  logic [3:0] rd_nrec = 4'd0;
  logic       out_ready = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_last;
  logic [2:0] out_rec;
  logic [3:0] rec_count;
  logic       slice_done;

  always #4 clk = ~clk;

  wseg_capture u0 (.*);

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  logic [7:0] dat [16384];
  bit         vld_a [16384];
  int trig_cyc [8];
  int pre_l, post_l, dly_l, waves_l, nrec_b;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  task automatic tick(input bit v, input bit t, input bit a);
    @(negedge clk);
    adc_data = 8'((cyc * 37 + 11) & 255);
    adc_vld  = v;
    trig     = t;
    arm      = a;
    dat[cyc]   = adc_data;
    vld_a[cyc] = v;
    cyc++;
  endtask

  function automatic int exp_sample(int r, int k);
    int c;
    int n;
    n = 0;
    if (k < pre_l) begin
      c = trig_cyc[r];
      while (c >= 0) begin
        if (vld_a[c]) begin
          if (n == pre_l - 1 - k) return int'(dat[c]);
          n++;
        end
        c--;
      end
      return -1;
    end
    c = trig_cyc[r] + dly_l + 1;
    while (c < cyc) begin
      if (vld_a[c]) begin
        if (n == k - pre_l) return int'(dat[c]);
        n++;
      end
      c++;
    end
    return -1;
  endfunction

  task automatic arm_cfg(input int p, input int q, input int d, input int w);
    cfg_pre_len = 5'(p); cfg_post_len = 5'(q); cfg_delay = 8'(d); cfg_waves = 4'(w);
    pre_l = p; post_l = q; dly_l = d; waves_l = w; nrec_b = 0;
    tick(1, 1, 1);
    tick(0, 0, 0);
    chk(rec_count == 0 && !slice_done, "R2 arm clears status", int'(rec_count), 0);
  endtask

  // One record: early (ignored) trigger, fill, trigger, delay, post with stray triggers.
  task automatic capture(input int extra, input bit gaps);
    int cnt;
    int got;
    int i;
    tick(1, 1, 0);  // R3: ring empty, trigger must be ignored
    cnt = 1;
    i = 0;
    while (cnt < pre_l + extra) begin
      automatic bit v = gaps ? (i % 2 == 0) : 1'b1;
      tick(v, 0, 0);
      cnt += int'(v);
      i++;
    end
    trig_cyc[nrec_b] = cyc;
    tick(1, 1, 0);
    for (int d = 0; d < dly_l; d++) tick(1, d == 0, 0);  // R6 trigger in delay
    got = 0;
    i = 0;
    while (got < post_l) begin
      automatic bit v = gaps ? (i % 2 == 1) : 1'b1;
      tick(v, i == 0, 0);  // R6 trigger in post phase
      got += int'(v);
      i++;
    end
    nrec_b++;
    tick(0, 0, 0);
    chk(int'(rec_count) == nrec_b, "R8 R3 R6 record count", int'(rec_count), nrec_b);
    chk(slice_done == (nrec_b >= waves_l), "R8 slice_done", int'(slice_done),
        int'(nrec_b >= waves_l));
  endtask

  task automatic readout(input int nreq, input string tag);
    int nexp;
    int len;
    int r;
    int k;
    int beats;
    int guard;
    bit hold;
    logic [7:0] held;
    nexp = (nreq < nrec_b) ? nreq : nrec_b;
    len = pre_l + post_l;
    @(negedge clk);
    rd_req = 1'b1;
    rd_nrec = 4'(nreq);
    @(negedge clk);
    rd_req = 1'b0;
    r = 0; k = 0; beats = 0; guard = 0; hold = 0; held = '0;
    while (beats < nexp * len && guard < 4000) begin
      automatic bit rdy = (guard % 3) != 2;
      if (hold)
        chk(out_valid && out_data == held, "R10 stalled beat held", int'(out_data), int'(held));
      if (out_valid) begin
        automatic int e = exp_sample(r, k);
        chk(int'(out_data) == e, (k < pre_l) ? {tag, " R4 R7 pre sample"} :
            {tag, " R5 R7 post sample"}, int'(out_data), e);
        chk(out_last == (k == len - 1), "R9 last flag", int'(out_last), int'(k == len - 1));
        chk(int'(out_rec) == r, "R9 record index", int'(out_rec), r);
      end
      out_ready = rdy;
      hold = out_valid && !rdy;
      held = out_data;
      if (out_valid && rdy) begin
        beats++;
        if (k == len - 1) begin k = 0; r++; end
        else k++;
      end
      guard++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(beats == nexp * len, "R9 beat count", beats, nexp * len);
    for (int j = 0; j < 3; j++) begin
      chk(!out_valid, "R9 stream ends", int'(out_valid), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL R9 watchdog: actual running, expected finished");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rec_count == 0, "R1 reset count", int'(rec_count), 0);
    chk(!slice_done, "R1 reset slice_done", int'(slice_done), 0);
    chk(!out_valid, "R1 reset out_valid", int'(out_valid), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 30; i++) tick(1, i % 4 == 3, 0);
    tick(0, 0, 0);
    chk(rec_count == 0, "R1 nothing before arm", int'(rec_count), 0);

    // Directed slice: three records, gaps in the middle one.
    arm_cfg(5, 4, 2, 3);
    capture(0, 1'b0);
    capture(3, 1'b1);
    capture(7, 1'b0);
    for (int i = 0; i < 12; i++) tick(1, 1, 0);
    chk(rec_count == 3 && slice_done, "R8 halted after slice", int'(rec_count), 3);
    readout(0, "R9");
    readout(8, "R9");
    readout(1, "R11");

    // Sweep of ring length, post length, delay, rotation and gaps.
    for (int pi = 0; pi < 3; pi++)
      for (int qi = 0; qi < 3; qi++)
        for (int di = 0; di < 3; di++) begin
          automatic int p = (pi == 0) ? 1 : (pi == 1) ? 3 : 16;
          automatic int q = (qi == 0) ? 1 : (qi == 1) ? 5 : 16;
          automatic int d = (di == 0) ? 0 : (di == 1) ? 1 : 5;
          automatic bit g = ((pi + qi + di) % 2) == 1;
          arm_cfg(p, q, d, 2);
          capture((qi * 5 + di * 3) % 7, g);
          capture((pi * 3 + qi) % 5, !g);
          readout(3, "R9");
          readout(1, "R11");
        end
    finish_up();
  end

endmodule